// File: doc/BRIEF.md
# Shared-Bus Four-State Value Resolver

The block takes the values that several drivers place on one shared wire and works out the single value that the wire carries. Each driver can hold one of four states: logic 0, logic 1, high impedance (Z) and unknown (X). The resolver applies the usual wired-bus rules to all of them. An unknown from any driver makes the result unknown. Two drivers that disagree give unknown. A driven level beats high impedance. The wire floats only when no driver is active.

The block also raises a conflict flag when more than one driver is active in the same cycle, even when those drivers agree. This lets a simulation model or a bus monitor report a failure of tri-state arbitration. The driver count is a parameter from 1 to 16. The drivers arrive as one packed vector of 2-bit fields. The resolved value and the flag are registered, so they appear one clock after the inputs are sampled.

Top module: `bus_resolver`

## Requirements
- R1: Every 2-bit field, on the inputs and on the output, uses the code 2'b00 = logic 0, 2'b01 = logic 1, 2'b10 = Z and 2'b11 = X. Driver i occupies bits [2i+1:2i] of `drv_vec`.
- R2: When at least one driver is at 0, at least one driver is at 1 and no driver is at X, the result is X.
- R3: When any driver is at X, the result is X, whatever the other drivers hold and whatever their position relative to the X driver.
- R4: When no driver is at X and every non-Z driver carries the same level, the result is that level. Z drivers have no effect on it.
- R5: The result is Z only when every driver is Z.
- R6: `conflict_q` is 1 when two or more drivers are not Z, including when they all agree. It is 0 when at most one driver is not Z.
- R7: With a single driver, the result equals that driver's value and `conflict_q` stays 0.
- R8: Both outputs are registered and take the value computed from the inputs sampled at the previous rising clock edge. While `rst_n` is low, `bus_q` is Z (2'b10) and `conflict_q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_vec | input | 2*N_DRV | Packed driver values, two bits per driver |
| bus_q | output | 2 | Registered resolved bus value |
| conflict_q | output | 1 | Registered flag: two or more drivers active |

## Verification
Value resolution and conflict detection act on the same input vector, so they happen in the same cycle every time two drivers are active. The relation to test is whether the flag depends only on the number of active drivers, while the resolved value depends on which levels those drivers carry. The bench sweeps every combination of four drivers. This covers agreeing pairs, which must give a clean level together with a raised flag. It also covers disagreeing pairs, which must give X together with the flag, and cases where X shares the bus with driven levels. For each vector, the bench counts the zeros, ones, X values and active drivers, and checks both registered outputs in the same sampling slot.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;

    typedef enum logic [1:0] {
        BV_LO  = 2'b00,
        BV_HI  = 2'b01,
        BV_OFF = 2'b10,
        BV_UNK = 2'b11
    } bus_val_e;

    // Pairwise wired resolution: unknown wins, floating yields, disagreement is unknown.
    function automatic bus_val_e merge_pair(input bus_val_e a, input bus_val_e b);
        bus_val_e r;
        if (a == BV_UNK || b == BV_UNK) begin
            r = BV_UNK;
        end else if (a == BV_OFF) begin
            r = b;
        end else if (b == BV_OFF) begin
            r = a;
        end else if (a == b) begin
            r = a;
        end else begin
            r = BV_UNK;
        end
        return r;
    endfunction

endpackage

// File: rtl/bus_res_cell.sv
module bus_res_cell
    import bus_res_pkg::*;
(
    input  logic [1:0] acc_in,
    input  logic [1:0] drv_in,
    output logic [1:0] acc_out
);
    bus_val_e merged;

    always_comb begin
        merged  = merge_pair(bus_val_e'(acc_in), bus_val_e'(drv_in));
        acc_out = merged;
    end

    // R3: once the accumulated value is unknown, a further driver cannot clear it
    always_comb begin
        if (acc_in == BV_UNK) begin
            AST_UNK_STICKY: assert (acc_out == BV_UNK); // R3
        end
    end
endmodule

// File: rtl/bus_res_activity.sv
module bus_res_activity
    import bus_res_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic [2*N_DRV-1:0] drv_vec,
    output logic               multi
);
    generate
        if (N_DRV == 1) begin : g_single
            assign multi = 1'b0;
        end else begin : g_many
            always_comb begin
                logic seen;
                seen  = 1'b0;
                multi = 1'b0;
                for (int i = 0; i < N_DRV; i++) begin
                    if (drv_vec[2*i +: 2] != BV_OFF) begin
                        if (seen) begin
                            multi = 1'b1;
                        end
                        seen = 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bus_resolver.sv
module bus_resolver
    import bus_res_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*N_DRV-1:0] drv_vec,
    output logic [1:0]         bus_q,
    output logic               conflict_q
);
    localparam int VEC_W = 2 * N_DRV;

    typedef struct packed {
        bus_val_e bus;
        logic     conflict;
    } res_regs_t;

    res_regs_t r_d, r_q;

    logic [1:0] chain_w [N_DRV];
    logic       multi_w;

    assign chain_w[0] = drv_vec[1:0];

    generate
        for (genvar gi = 1; gi < N_DRV; gi++) begin : g_chain
            bus_res_cell u_cell (
                .acc_in  (chain_w[gi-1]),
                .drv_in  (drv_vec[2*gi +: 2]),
                .acc_out (chain_w[gi])
            );
        end
    endgenerate

    bus_res_activity #(.N_DRV(N_DRV)) u_activity (
        .drv_vec (drv_vec),
        .multi   (multi_w)
    );

    always_comb begin
        r_d          = r_q;
        r_d.bus      = bus_val_e'(chain_w[N_DRV-1]);
        r_d.conflict = multi_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{bus: BV_OFF, conflict: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_q      = r_q.bus;
    assign conflict_q = r_q.conflict;

    // Level summary of the raw inputs, used only by the checks below.
    logic any_lo, any_hi, any_unk, all_off;
    always_comb begin
        any_lo  = 1'b0;
        any_hi  = 1'b0;
        any_unk = 1'b0;
        all_off = 1'b1;
        for (int i = 0; i < VEC_W / 2; i++) begin
            if (drv_vec[2*i +: 2] == BV_LO)  any_lo  = 1'b1;
            if (drv_vec[2*i +: 2] == BV_HI)  any_hi  = 1'b1;
            if (drv_vec[2*i +: 2] == BV_UNK) any_unk = 1'b1;
            if (drv_vec[2*i +: 2] != BV_OFF) all_off = 1'b0;
        end
    end

    AST_LO_HI_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_lo && any_hi) |=> (bus_q == BV_UNK)); // R2
    AST_UNK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any_unk |=> (bus_q == BV_UNK)); // R3
    AST_CLEAN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (any_lo && !any_hi && !any_unk) |=> (bus_q == BV_LO)); // R4
    AST_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> (bus_q == BV_OFF && !conflict_q)); // R5
    AST_FLOAT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !all_off |=> (bus_q != BV_OFF)); // R5
    AST_CONFLICT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_q |-> (bus_q != BV_OFF)); // R6

    generate
        if (N_DRV == 1) begin : g_one_chk
            AST_SOLO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (bus_q == $past(drv_vec[1:0]) && !conflict_q)); // R7
        end
    endgenerate
endmodule

// File: tb/bus_resolver_bench.sv
module bus_resolver_bench;
    localparam int NW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NW-1:0] drv4 = '0;
    logic [1:0]      drv1 = 2'b10;
    logic [1:0]      bus4, bus1;
    logic            conf4, conf1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bus_resolver #(.N_DRV(NW)) u_bus_resolver (
        .clk(clk), .rst_n(rst_n), .drv_vec(drv4), .bus_q(bus4), .conflict_q(conf4)
    );

    bus_resolver #(.N_DRV(1)) u_bus_resolver_solo (
        .clk(clk), .rst_n(rst_n), .drv_vec(drv1), .bus_q(bus1), .conflict_q(conf1)
    );

    task automatic check(input string req, input int act, input int exp, input int vec);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s vec=%0h actual=%0d expected=%0d", req, vec, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL R8 watchdog expired actual=%0d expected<=20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (2) @(negedge clk);
        check("R8 reset bus", bus4, 2, 0);
        check("R8 reset conflict", conf4, 0, 0);
        check("R8 reset solo bus", bus1, 2, 0);
        rst_n = 1'b1;

        // R1 codes: 0=00, 1=01, Z=10, X=11; driver i at bits [2i+1:2i]
        for (int v = 0; v < 256; v++) begin
            int n0, n1, nz, nx, act, eb;
            @(negedge clk);
            drv4 = v[7:0];
            n0 = 0; n1 = 0; nz = 0; nx = 0;
            for (int i = 0; i < NW; i++) begin
                case ((v >> (2*i)) & 3)
                    0: n0++;
                    1: n1++;
                    2: nz++;
                    default: nx++;
                endcase
            end
            act = NW - nz;
            @(negedge clk);
            if (nx > 0) begin
                eb = 3;
                check("R3 unknown dominates", bus4, eb, v);
            end else if (n0 > 0 && n1 > 0) begin
                eb = 3;
                check("R2 opposing levels", bus4, eb, v);
            end else if (act == 0) begin
                eb = 2;
                check("R5 all floating", bus4, eb, v);
            end else begin
                eb = (n1 > 0) ? 1 : 0;
                check("R4 level over floating", bus4, eb, v);
            end
            check("R6 conflict flag", conf4, (act >= 2) ? 1 : 0, v);
        end

        // R7: single driver passes through, never flags
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            drv1 = v[1:0];
            @(negedge clk);
            check("R7 solo value", bus1, v, v);
            check("R7 solo conflict", conf1, 0, v);
        end

        // R8: output holds previous sample until the next edge
        @(negedge clk);
        drv4 = 8'b10_10_10_01;
        @(negedge clk);
        drv4 = 8'b00_10_10_10;
        check("R8 one-cycle latency", bus4, 1, 8'h A9);
        @(negedge clk);
        check("R8 follow-up", bus4, 0, 8'h2A);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule